// File: doc/BRIEF.md
# EEPROM Command Sequencer

This block turns single command bytes from a serial receive port into fixed transactions on a two-wire EEPROM bus. It sits between a byte-wide serial receiver/transmitter and a byte-level two-wire bus engine. The serial framing (8 data bits, no parity, one stop bit, 9600 baud) and the bus bit timing are handled outside it. It only exchanges whole bytes and engine requests, each through a valid/ready handshake.

Two command bytes are recognised. Command 0x01 stores the constant 0x14 at word address 0 of the memory. Command 0x02 reads two consecutive bytes starting at word address 0, using a repeated start, and returns them on the transmit side. Each accepted command is echoed before any bus activity. If the memory fails to acknowledge an address or data byte, the block closes the bus with a stop and replies with the single error byte 0x11. Any other received byte, and any byte that arrives while a command is running, is dropped.

Each engine request is one step. The engine must answer every accepted request with exactly one response. The response carries a NACK flag for start, repeated start and write steps, and carries the received byte for read steps.

Top module: `eeprom_cmd_seq`

## Requirements
- R1: After reset, `busy`, `tx_valid` and `eng_req_valid` are low.
- R2: Command byte 0x01 or 0x02 received while idle is echoed once on the transmit side. The echo is sent before the first engine request of that command.
- R3: Engine step codes are start=0, repeated start=1, write=2, read=3 and stop=4. Command 0x01 issues these steps in order: start with data 0xA0, write 0x00, write 0x14, stop.
- R4: Command 0x02 issues these steps in order: start with 0xA0, write 0x00, repeated start with 0xA1, read with `eng_req_ack`=1, read with `eng_req_ack`=0, stop. Here `eng_req_ack`=1 means the master acknowledges the byte.
- R5: After the stop of command 0x02 completes, the first read byte is transmitted, then the second. Each byte is held until `tx_ready` accepts it.
- R6: A NACK response to a start, repeated start or write step abandons the command. The next request is a stop, and after it the single byte 0x11 is transmitted. No further steps are issued.
- R7: A received byte other than 0x01 or 0x02 gives no echo, no engine request and no `busy`.
- R8: Bytes received while `busy` is high are dropped and cause no extra activity.
- R9: `busy` rises in the cycle after a command is accepted. It stays high until the final transmit byte (or, for a write without error, the stop response) has been taken.
- R10: `tx_valid`/`tx_data` and the engine request fields stay stable while their ready input is low.
- R11: At most one engine request is outstanding. `eng_req_valid` drops after a request is accepted, and never overlaps `tx_valid`.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| rx_valid | input | 1 | Received byte strobe |
| rx_data | input | 8 | Received byte |
| tx_valid | output | 1 | Byte offered to transmitter |
| tx_data | output | 8 | Byte to transmit |
| tx_ready | input | 1 | Transmitter takes the byte |
| eng_req_valid | output | 1 | Engine step request valid |
| eng_req_op | output | 3 | Step code (see R3) |
| eng_req_data | output | 8 | Byte to send for start/restart/write |
| eng_req_ack | output | 1 | For reads: 1 = acknowledge, 0 = not acknowledge |
| eng_req_ready | input | 1 | Engine accepts the request |
| eng_rsp_valid | input | 1 | Engine step completed |
| eng_rsp_data | input | 8 | Byte read by a read step |
| eng_rsp_nack | input | 1 | Slave did not acknowledge (start/restart/write) |
| busy | output | 1 | Command in progress |

## Verification
On every cycle, the assertions check the handshake rules: requests and transmit bytes are held while stalled, only one request is outstanding, and transmit never overlaps a request. They also check that a NACK on an acknowledged step is followed at once by a stop request, that `busy` and the echo rise right after a valid command, and that unknown bytes leave the block idle. The bench scenarios are needed to show the exact step lists of both commands and where each abort point truncates them. They also show the order and values of the returned bytes, and that commands injected mid-sequence leave no trace.

// File: rtl/eeprom_seq_pkg.sv
package eeprom_seq_pkg;

    localparam int DW      = 8;
    localparam int IDX_W   = 3;

    typedef enum logic [2:0] {
        OP_START   = 3'd0,
        OP_RESTART = 3'd1,
        OP_WRITE   = 3'd2,
        OP_READ    = 3'd3,
        OP_STOP    = 3'd4
    } bus_op_e;

    typedef enum logic [1:0] {
        JOB_NONE  = 2'd0,
        JOB_WRITE = 2'd1,
        JOB_READ  = 2'd2
    } job_e;

    typedef struct packed {
        bus_op_e         op;
        logic [DW-1:0]   data;
        logic            ack;
        logic            last;
    } step_t;

    typedef enum logic [2:0] {
        S_IDLE,
        S_ECHO,
        S_ISSUE,
        S_WAIT,
        S_ABORT_ISSUE,
        S_ABORT_WAIT,
        S_ERR_TX,
        S_DATA_TX
    } seq_state_e;

    function automatic logic needs_slave_ack(bus_op_e op);
        return (op == OP_START) || (op == OP_RESTART) || (op == OP_WRITE);
    endfunction

    function automatic step_t mk_step(bus_op_e op, logic [DW-1:0] data,
                                      logic ack, logic last);
        step_t s;
        s.op   = op;
        s.data = data;
        s.ack  = ack;
        s.last = last;
        return s;
    endfunction

endpackage

// File: rtl/seq_cmd_decode.sv
module seq_cmd_decode
    import eeprom_seq_pkg::*;
#(
    parameter logic [DW-1:0] CODE_WRITE = 8'h01,
    parameter logic [DW-1:0] CODE_READ  = 8'h02
) (
    input  logic          valid,
    input  logic [DW-1:0] byte_in,
    output job_e          job
);
    always_comb begin
        job = JOB_NONE;
        if (valid) begin
            if (byte_in == CODE_WRITE)
                job = JOB_WRITE;
            else if (byte_in == CODE_READ)
                job = JOB_READ;
        end
    end
endmodule

// File: rtl/seq_step_gen.sv
module seq_step_gen
    import eeprom_seq_pkg::*;
#(
    parameter logic [6:0]    DEV_ADDR  = 7'h50,
    parameter logic [DW-1:0] WORD_ADDR = 8'h00,
    parameter logic [DW-1:0] WR_VALUE  = 8'h14
) (
    input  job_e             job,
    input  logic [IDX_W-1:0] idx,
    output step_t            step
);
    localparam logic [DW-1:0] DEV_WR = {DEV_ADDR, 1'b0};
    localparam logic [DW-1:0] DEV_RD = {DEV_ADDR, 1'b1};

    always_comb begin
        step = mk_step(OP_STOP, '0, 1'b0, 1'b1);
        if (job == JOB_WRITE) begin
            case (idx)
                3'd0:    step = mk_step(OP_START, DEV_WR,    1'b0, 1'b0);
                3'd1:    step = mk_step(OP_WRITE, WORD_ADDR, 1'b0, 1'b0);
                3'd2:    step = mk_step(OP_WRITE, WR_VALUE,  1'b0, 1'b0);
                default: step = mk_step(OP_STOP,  '0,        1'b0, 1'b1);
            endcase
        end else if (job == JOB_READ) begin
            case (idx)
                3'd0:    step = mk_step(OP_START,   DEV_WR,    1'b0, 1'b0);
                3'd1:    step = mk_step(OP_WRITE,   WORD_ADDR, 1'b0, 1'b0);
                3'd2:    step = mk_step(OP_RESTART, DEV_RD,    1'b0, 1'b0);
                3'd3:    step = mk_step(OP_READ,    '0,        1'b1, 1'b0);
                3'd4:    step = mk_step(OP_READ,    '0,        1'b0, 1'b0);
                default: step = mk_step(OP_STOP,    '0,        1'b0, 1'b1);
            endcase
        end
    end
endmodule

// File: rtl/seq_read_store.sv
module seq_read_store
    import eeprom_seq_pkg::*;
#(
    parameter int NUM_BYTES = 2
) (
    input  logic                    clk,
    input  logic                    rst,
    input  logic                    clear,
    input  logic                    cap_valid,
    input  logic [DW-1:0]           cap_data,
    output logic [NUM_BYTES*DW-1:0] bytes_out
);
    localparam int PTR_W = $clog2(NUM_BYTES + 1);

    logic [PTR_W-1:0] wr_ptr;

    always_ff @(posedge clk) begin
        if (rst || clear)
            wr_ptr <= '0;
        else if (cap_valid && (wr_ptr < PTR_W'(NUM_BYTES)))
            wr_ptr <= wr_ptr + 1'b1;
    end

    for (genvar g = 0; g < NUM_BYTES; g++) begin : g_slot
        logic [DW-1:0] slot_q;
        always_ff @(posedge clk) begin
            if (rst)
                slot_q <= '0;
            else if (cap_valid && (wr_ptr == PTR_W'(g)))
                slot_q <= cap_data;
        end
        assign bytes_out[g*DW +: DW] = slot_q;
    end

    assert_ptr_bound_R5: assert property (@(posedge clk) disable iff (rst)
        wr_ptr <= PTR_W'(NUM_BYTES));

endmodule

// File: rtl/eeprom_cmd_seq.sv
module eeprom_cmd_seq
    import eeprom_seq_pkg::*;
#(
    parameter logic [7:0] CODE_WRITE = 8'h01,
    parameter logic [7:0] CODE_READ  = 8'h02,
    parameter logic [7:0] ERR_CODE   = 8'h11,
    parameter logic [6:0] DEV_ADDR   = 7'h50,
    parameter logic [7:0] WORD_ADDR  = 8'h00,
    parameter logic [7:0] WR_VALUE   = 8'h14
) (
    input  logic       clk,
    input  logic       rst,
    input  logic       rx_valid,
    input  logic [7:0] rx_data,
    output logic       tx_valid,
    output logic [7:0] tx_data,
    input  logic       tx_ready,
    output logic       eng_req_valid,
    output logic [2:0] eng_req_op,
    output logic [7:0] eng_req_data,
    output logic       eng_req_ack,
    input  logic       eng_req_ready,
    input  logic       eng_rsp_valid,
    input  logic [7:0] eng_rsp_data,
    input  logic       eng_rsp_nack,
    output logic       busy
);
    localparam int NUM_RD = 2;
    localparam int TXI_W  = $clog2(NUM_RD);

    seq_state_e        st;
    job_e              job_q;
    job_e              job_in;
    logic [IDX_W-1:0]  idx;
    logic [TXI_W-1:0]  txi;
    step_t             step;
    logic [NUM_RD*DW-1:0] rd_bytes;
    logic              accept_cmd;
    logic              cap_valid;
    logic              slave_nacked;

    seq_cmd_decode #(.CODE_WRITE(CODE_WRITE), .CODE_READ(CODE_READ)) i_decode (
        .valid   (rx_valid),
        .byte_in (rx_data),
        .job     (job_in)
    );

    seq_step_gen #(.DEV_ADDR(DEV_ADDR), .WORD_ADDR(WORD_ADDR), .WR_VALUE(WR_VALUE)) i_steps (
        .job  (job_q),
        .idx  (idx),
        .step (step)
    );

    assign accept_cmd   = (st == S_IDLE) && (job_in != JOB_NONE);
    assign cap_valid    = (st == S_WAIT) && eng_rsp_valid && (step.op == OP_READ);
    assign slave_nacked = eng_rsp_nack && needs_slave_ack(step.op);

    seq_read_store #(.NUM_BYTES(NUM_RD)) i_store (
        .clk       (clk),
        .rst       (rst),
        .clear     (accept_cmd),
        .cap_valid (cap_valid),
        .cap_data  (eng_rsp_data),
        .bytes_out (rd_bytes)
    );

    always_ff @(posedge clk) begin
        if (rst) begin
            st    <= S_IDLE;
            job_q <= JOB_NONE;
            idx   <= '0;
            txi   <= '0;
        end else begin
            case (st)
                S_IDLE: begin
                    if (accept_cmd) begin
                        job_q <= job_in;
                        idx   <= '0;
                        txi   <= '0;
                        st    <= S_ECHO;
                    end
                end
                S_ECHO: begin
                    if (tx_ready) st <= S_ISSUE;
                end
                S_ISSUE: begin
                    if (eng_req_ready) st <= S_WAIT;
                end
                S_WAIT: begin
                    if (eng_rsp_valid) begin
                        if (slave_nacked)
                            st <= S_ABORT_ISSUE;
                        else if (step.last)
                            st <= (job_q == JOB_READ) ? S_DATA_TX : S_IDLE;
                        else begin
                            idx <= idx + 1'b1;
                            st  <= S_ISSUE;
                        end
                    end
                end
                S_ABORT_ISSUE: begin
                    if (eng_req_ready) st <= S_ABORT_WAIT;
                end
                S_ABORT_WAIT: begin
                    if (eng_rsp_valid) st <= S_ERR_TX;
                end
                S_ERR_TX: begin
                    if (tx_ready) st <= S_IDLE;
                end
                S_DATA_TX: begin
                    if (tx_ready) begin
                        if (txi == TXI_W'(NUM_RD - 1))
                            st <= S_IDLE;
                        else
                            txi <= txi + 1'b1;
                    end
                end
                default: st <= S_IDLE;
            endcase
        end
    end

    always_comb begin
        tx_valid = 1'b0;
        tx_data  = '0;
        case (st)
            S_ECHO: begin
                tx_valid = 1'b1;
                tx_data  = (job_q == JOB_WRITE) ? CODE_WRITE : CODE_READ;
            end
            S_ERR_TX: begin
                tx_valid = 1'b1;
                tx_data  = ERR_CODE;
            end
            S_DATA_TX: begin
                tx_valid = 1'b1;
                tx_data  = rd_bytes[txi*DW +: DW];
            end
            default: ;
        endcase
    end

    always_comb begin
        eng_req_valid = 1'b0;
        eng_req_op    = OP_STOP;
        eng_req_data  = '0;
        eng_req_ack   = 1'b0;
        if (st == S_ISSUE) begin
            eng_req_valid = 1'b1;
            eng_req_op    = step.op;
            eng_req_data  = step.data;
            eng_req_ack   = step.ack;
        end else if (st == S_ABORT_ISSUE) begin
            eng_req_valid = 1'b1;
        end
    end

    assign busy = (st != S_IDLE);

    assert_req_hold_R10: assert property (@(posedge clk) disable iff (rst)
        eng_req_valid && !eng_req_ready |=> eng_req_valid && $stable(eng_req_op)
            && $stable(eng_req_data) && $stable(eng_req_ack));

    assert_tx_hold_R10: assert property (@(posedge clk) disable iff (rst)
        tx_valid && !tx_ready |=> tx_valid && $stable(tx_data));

    assert_single_req_R11: assert property (@(posedge clk) disable iff (rst)
        eng_req_valid && eng_req_ready |=> !eng_req_valid);

    assert_no_overlap_R11: assert property (@(posedge clk) disable iff (rst)
        !(tx_valid && eng_req_valid));

    assert_nack_stop_R6: assert property (@(posedge clk) disable iff (rst)
        (st == S_WAIT) && eng_rsp_valid && slave_nacked
            |=> eng_req_valid && (eng_req_op == OP_STOP));

    assert_cmd_start_R9: assert property (@(posedge clk) disable iff (rst)
        !busy && (job_in != JOB_NONE) |=> busy && tx_valid);

    assert_ignore_R7: assert property (@(posedge clk) disable iff (rst)
        !busy && rx_valid && (job_in == JOB_NONE) |=> !busy && !tx_valid && !eng_req_valid);

endmodule

// File: tb/test_eeprom_cmd_seq.sv
module test_eeprom_cmd_seq;

    logic       clk = 1'b0;
    logic       rst;
    logic       rx_valid, tx_ready, eng_req_ready, eng_rsp_valid, eng_rsp_nack;
    logic [7:0] rx_data, eng_rsp_data;
    logic       tx_valid, eng_req_valid, eng_req_ack, busy;
    logic [7:0] tx_data, eng_req_data;
    logic [2:0] eng_req_op;

    int errors = 0;
    int checks = 0;

    always #2.5 clk = ~clk;

    eeprom_cmd_seq i_eeprom_cmd_seq (
        .clk(clk), .rst(rst),
        .rx_valid(rx_valid), .rx_data(rx_data),
        .tx_valid(tx_valid), .tx_data(tx_data), .tx_ready(tx_ready),
        .eng_req_valid(eng_req_valid), .eng_req_op(eng_req_op),
        .eng_req_data(eng_req_data), .eng_req_ack(eng_req_ack),
        .eng_req_ready(eng_req_ready),
        .eng_rsp_valid(eng_rsp_valid), .eng_rsp_data(eng_rsp_data),
        .eng_rsp_nack(eng_rsp_nack), .busy(busy)
    );

    logic [2:0] got_op  [16];
    logic [7:0] got_dat [16];
    logic       got_ack [16];
    int         got_n;
    logic [7:0] got_tx  [8];
    int         got_tx_reqs [8];
    int         got_ntx;

    logic [2:0] exp_op  [16];
    logic [7:0] exp_dat [16];
    logic       exp_ack [16];
    int         exp_n;
    logic [7:0] exp_tx  [8];
    int         exp_ntx;

    task automatic check(input bit ok, input string req, input int act, input int exp);
        checks++;
        if (!ok) begin
            errors++;
            $display("FAIL %s: actual=%0h expected=%0h", req, act, exp);
        end
    endtask

    task automatic add_exp(input logic [2:0] op, input logic [7:0] d, input logic a);
        exp_op[exp_n] = op; exp_dat[exp_n] = d; exp_ack[exp_n] = a; exp_n++;
    endtask

    task automatic build_expected(input logic [7:0] cmd, input int nack_at,
                                  input logic [7:0] r0, input logic [7:0] r1);
        logic [2:0] lop [6];
        logic [7:0] ldat [6];
        logic       lack [6];
        int         len;
        bit         aborted;
        exp_n = 0; exp_ntx = 0; aborted = 0;
        if (cmd == 8'h01) begin
            lop[0]=0; ldat[0]=8'hA0; lack[0]=0;
            lop[1]=2; ldat[1]=8'h00; lack[1]=0;
            lop[2]=2; ldat[2]=8'h14; lack[2]=0;
            lop[3]=4; ldat[3]=8'h00; lack[3]=0;
            len = 4;
        end else begin
            lop[0]=0; ldat[0]=8'hA0; lack[0]=0;
            lop[1]=2; ldat[1]=8'h00; lack[1]=0;
            lop[2]=1; ldat[2]=8'hA1; lack[2]=0;
            lop[3]=3; ldat[3]=8'h00; lack[3]=1;
            lop[4]=3; ldat[4]=8'h00; lack[4]=0;
            lop[5]=4; ldat[5]=8'h00; lack[5]=0;
            len = 6;
        end
        for (int i = 0; i < len; i++) begin
            add_exp(lop[i], ldat[i], lack[i]);
            if (i == nack_at) begin
                add_exp(3'd4, 8'h00, 1'b0);
                aborted = 1;
                break;
            end
        end
        exp_tx[exp_ntx++] = cmd;
        if (aborted)
            exp_tx[exp_ntx++] = 8'h11;
        else if (cmd == 8'h02) begin
            exp_tx[exp_ntx++] = r0;
            exp_tx[exp_ntx++] = r1;
        end
    endtask

    task automatic run_cmd(input logic [7:0] cmd, input int nack_at,
                           input logic [7:0] r0, input logic [7:0] r1,
                           input int stall, input bit inject);
        bit         pend = 0;
        int         rd_cnt = 0;
        int         wait_left = 0;
        bit         tx_cur = 0;
        logic [7:0] tx_first = '0;
        bit         hold_ok = 1;
        got_n = 0; got_ntx = 0;
        @(negedge clk);
        rx_valid = 1'b1; rx_data = cmd;
        @(negedge clk);
        rx_valid = 1'b0;
        check(busy === 1'b1, "R9 busy after command", busy, 1);
        for (int c = 0; c < 400; c++) begin
            if (c > 0) @(negedge clk);
            tx_ready = 0; eng_req_ready = 0; eng_rsp_valid = 0; eng_rsp_nack = 0;
            rx_valid = 0;
            if (inject && (c == 3 || c == 9)) begin
                rx_valid = 1'b1; rx_data = (c == 3) ? 8'h01 : 8'h02;
            end
            if (!busy && !pend) break;
            if (pend) begin
                eng_rsp_valid = 1'b1;
                eng_rsp_nack  = ((got_n - 1) == nack_at);
                if (got_op[got_n-1] == 3'd3) begin
                    eng_rsp_data = (rd_cnt == 0) ? r0 : r1;
                    rd_cnt++;
                end else
                    eng_rsp_data = 8'h5A;
                pend = 0;
            end else if (eng_req_valid) begin
                if (got_n < 16) begin
                    got_op[got_n] = eng_req_op; got_dat[got_n] = eng_req_data;
                    got_ack[got_n] = eng_req_ack;
                end
                got_n++;
                eng_req_ready = 1'b1;
                pend = 1;
            end
            if (tx_valid) begin
                if (!tx_cur) begin
                    tx_cur = 1; tx_first = tx_data; wait_left = stall;
                end else if (tx_data !== tx_first)
                    hold_ok = 0;
                if (wait_left > 0)
                    wait_left--;
                else begin
                    if (got_ntx < 8) begin
                        got_tx[got_ntx] = tx_data; got_tx_reqs[got_ntx] = got_n;
                    end
                    got_ntx++;
                    tx_ready = 1'b1;
                    tx_cur = 0;
                end
            end
        end
        rx_valid = 0;
        check(hold_ok, "R10 tx byte held while stalled", 0, 0);
        build_expected(cmd, nack_at, r0, r1);
        check(got_n == exp_n, (cmd == 1) ? "R3 step count" : "R4/R6 step count", got_n, exp_n);
        for (int i = 0; i < exp_n && i < got_n; i++) begin
            check(got_op[i] == exp_op[i], (nack_at >= 0) ? "R6 step op" : (cmd == 1 ? "R3 step op" : "R4 step op"),
                  got_op[i], exp_op[i]);
            if (exp_op[i] <= 3'd2)
                check(got_dat[i] == exp_dat[i], cmd == 1 ? "R3 step data" : "R4 step data",
                      got_dat[i], exp_dat[i]);
            if (exp_op[i] == 3'd3)
                check(got_ack[i] == exp_ack[i], "R4 read ack", got_ack[i], exp_ack[i]);
        end
        check(got_ntx == exp_ntx, "R5/R6 tx count", got_ntx, exp_ntx);
        for (int i = 0; i < exp_ntx && i < got_ntx; i++)
            check(got_tx[i] == exp_tx[i], (i == 0) ? "R2 echo" : (nack_at >= 0 ? "R6 error byte" : "R5 read byte"),
                  got_tx[i], exp_tx[i]);
        if (got_ntx > 0)
            check(got_tx_reqs[0] == 0, "R2 echo before bus", got_tx_reqs[0], 0);
        for (int k = 0; k < 4; k++) begin
            @(negedge clk);
            check(!busy && !tx_valid && !eng_req_valid, "R8 no trailing activity",
                  {busy, tx_valid, eng_req_valid}, 0);
        end
    endtask

    initial begin
        for (int w = 0; w < 150000; w++) @(posedge clk);
        errors++;
        $display("FAIL watchdog: actual=timeout expected=finish");
        $display("Result: errors=%0d of %0d checks", errors, checks);
        $finish;
    end

    initial begin
        rst = 1; rx_valid = 0; rx_data = 0; tx_ready = 0;
        eng_req_ready = 0; eng_rsp_valid = 0; eng_rsp_data = 0; eng_rsp_nack = 0;
        repeat (3) @(negedge clk);
        rst = 0;
        @(negedge clk);
        check(!busy && !tx_valid && !eng_req_valid, "R1 reset state",
              {busy, tx_valid, eng_req_valid}, 0);

        for (int b = 0; b < 256; b++) begin
            if (b == 1 || b == 2) continue;
            rx_valid = 1'b1; rx_data = 8'(b);
            @(negedge clk);
            rx_valid = 1'b0;
            check(!busy && !tx_valid && !eng_req_valid, "R7 ignored byte",
                  {busy, tx_valid, eng_req_valid}, 0);
            @(negedge clk);
            check(!busy && !tx_valid && !eng_req_valid, "R7 ignored byte later",
                  {busy, tx_valid, eng_req_valid}, 0);
        end

        for (int cmd = 1; cmd <= 2; cmd++)
            for (int na = -1; na <= 2; na++)
                for (int st = 0; st <= 2; st++)
                    run_cmd(8'(cmd), na,
                            8'((cmd * 37 + st * 11 + na * 5) ^ 8'hC3),
                            8'((cmd * 91 + st * 23 + na * 3) ^ 8'h3C),
                            st, st == 1);

        $display("Result: errors=%0d of %0d checks", errors, checks);
        $finish;
    end

endmodule